// File: doc/BRIEF.md
# Framebuffer Descriptor DMA Fetcher

This block supplies a display controller with framebuffer words. It walks a chain of descriptors held in memory. Each descriptor is four consecutive 32-bit words. At every frame start the block reads the four words of the current descriptor. It then streams the buffer words the descriptor names into a pixel FIFO, using fixed-length read bursts on a simple burst-read memory port. When the data is done it keeps the next-descriptor pointer, and the following frame starts from that pointer. A descriptor whose pointer names its own address therefore repeats one frame forever.

Software loads the address of the first descriptor through a small register port. That write takes effect at the next frame boundary and never in the middle of a frame. The buffer address, frame id and command word of the descriptor in use can be read back. Command flags raise start-of-frame and end-of-frame pulses and mark palette data. A sticky status bit records a FIFO underflow.

Top module: `fb_desc_fetch`

## Requirements
- R1: After reset, mem_req, pix_valid, sof_flag, eof_flag, pal_flag and underflow are 0, and the register reads at offsets 0x40, 0x44, 0x48 and 0x4C return 0.
- R2: A frame start that is accepted issues one 4-word read at the current descriptor address. The beats are taken in this order: next pointer, buffer address, frame id, command. A pending request holds its address until the memory grants it.
- R3: Reads at 0x44, 0x48 and 0x4C return the buffer address, frame id and command of the last loaded descriptor. A read at 0x40 returns the head address. Writes to 0x44, 0x48 and 0x4C change nothing.
- R4: Command bits [LEN_W-1:0] give the transfer length in 32-bit words. Data bursts start at the buffer address and follow one another with no gap (the next address is the previous one plus 4 × its length). Their lengths add up to exactly the length field.
- R5: burst_sel chooses the burst length: 0 gives 4 words, 1 gives 8, 2 or 3 gives 16. Only the last burst of a descriptor is shorter, and then only when fewer words remain.
- R6: A data burst is requested only while the FIFO has room for a full burst of the selected length. With the consumer stalled, fetching stops once the FIFO is filled.
- R7: Command bit 31 gives a one-cycle sof_flag after the descriptor has loaded. Command bit 30 gives a one-cycle eof_flag after its data has been fetched. pal_flag follows command bit 28 of the loaded descriptor.
- R8: Each frame after the first loads the descriptor named by the previous next pointer. A pointer to itself reloads the same descriptor every frame.
- R9: A frame start before any write to 0x40 is ignored. A write to 0x40 during a frame does not change that frame, and the next frame start loads the new address.
- R10: underflow is set when pix_ready is high and the FIFO is empty while descriptor data is being fetched. Only reset clears it.
- R11: A descriptor with length 0 issues no data bursts but still completes and raises eof_flag when bit 30 is set.
- R12: pix_data presents the fetched words in address order, one word per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| burst_sel | input | 2 | Burst length select |
| frame_start | input | 1 | Frame boundary pulse from the timing generator |
| mem_req | output | 1 | Read burst request |
| mem_addr | output | 32 | Burst byte address |
| mem_len | output | 5 | Burst length in words |
| mem_gnt | input | 1 | Request accepted when high together with mem_req |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| pix_valid | output | 1 | FIFO holds a word |
| pix_data | output | 32 | FIFO head word |
| pix_ready | input | 1 | Consumer takes a word / pixel demand |
| sof_flag | output | 1 | Start-of-frame pulse |
| eof_flag | output | 1 | End-of-frame pulse |
| pal_flag | output | 1 | Loaded descriptor carries palette data |
| underflow | output | 1 | Sticky FIFO underflow status |

## Verification
The bench builds the block with FIFO_DEPTH=32 and LEN_W=12. With these values every length from 0 to 20 fits in the FIFO, so a sweep over all four burst selections reaches every remainder case of the final burst, including the zero-length descriptor. A 40-word descriptor with 16-word bursts fills the 32-entry FIFO after two bursts. This shows the room rule holding off the third burst, and it leaves time for a mid-frame head write whose effect must wait for the next frame.

// File: rtl/fbdf_pkg.sv
package fbdf_pkg;

  localparam int BURST_W = 5;

  localparam logic [7:0] OFS_HEAD = 8'h40;
  localparam logic [7:0] OFS_BUF  = 8'h44;
  localparam logic [7:0] OFS_ID   = 8'h48;
  localparam logic [7:0] OFS_CMD  = 8'h4C;

  localparam int CMD_SOF = 31;
  localparam int CMD_EOF = 30;
  localparam int CMD_PAL = 28;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DREQ,
    S_DWAIT,
    S_BREQ,
    S_BWAIT,
    S_FIN
  } fetch_state_e;

  // nominal burst size in words for a select code
  function automatic logic [BURST_W-1:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return BURST_W'(4);
      2'd1:    return BURST_W'(8);
      default: return BURST_W'(16);
    endcase
  endfunction

  // words in the next burst: nominal size, trimmed to what remains
  function automatic logic [BURST_W-1:0] chunk_len(input logic [31:0] rem,
                                                   input logic [BURST_W-1:0] nom);
    if (rem < {{(32-BURST_W){1'b0}}, nom}) return rem[BURST_W-1:0];
    return nom;
  endfunction

endpackage

// File: rtl/fbdf_fifo.sv
module fbdf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rdata = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: the fetcher must never write into a full FIFO
  assert_fifo_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R12: a pop on an empty FIFO would reorder or invent words
  assert_fifo_no_underrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> (count <= CW'(1)));

endmodule

// File: rtl/fbdf_regs.sv
module fbdf_regs
  import fbdf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        take,
  input  logic [31:0] sh_buf,
  input  logic [31:0] sh_id,
  input  logic [31:0] sh_cmd,
  output logic [31:0] head,
  output logic        head_pending,
  output logic        list_valid
);

  logic head_wr;
  assign head_wr = cfg_we && (cfg_addr == OFS_HEAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head         <= '0;
      head_pending <= 1'b0;
      list_valid   <= 1'b0;
    end else if (head_wr) begin
      head         <= cfg_wdata;
      head_pending <= 1'b1;
      list_valid   <= 1'b1;
    end else if (take) begin
      head_pending <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_HEAD: cfg_rdata = head;
      OFS_BUF:  cfg_rdata = sh_buf;
      OFS_ID:   cfg_rdata = sh_id;
      OFS_CMD:  cfg_rdata = sh_cmd;
      default:  cfg_rdata = '0;
    endcase
  end

  // R9: a head write is held pending until a frame start consumes it
  assert_head_write_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr |=> (head_pending && list_valid && head == $past(cfg_wdata)));

endmodule

// File: rtl/fbdf_engine.sv
module fbdf_engine
  import fbdf_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [1:0]         burst_sel,
  input  logic [31:0]        head,
  input  logic               head_pending,
  input  logic               list_valid,
  output logic               take,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  output logic [BURST_W-1:0] mem_len,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  input  logic [CW-1:0]      fifo_count,
  input  logic               fifo_empty,
  output logic               fifo_push,
  input  logic               pix_ready,
  output logic [31:0]        sh_buf,
  output logic [31:0]        sh_id,
  output logic [31:0]        sh_cmd,
  output logic               sof_flag,
  output logic               eof_flag,
  output logic               underflow
);

  fetch_state_e       state;
  logic [31:0]        cur_desc, nxt, ptr;
  logic [LEN_W-1:0]   remain;
  logic [BURST_W-1:0] beats;
  logic               sof_q;

  // named internal events
  logic [BURST_W-1:0] nominal, chunk;
  logic               room, accept, desc_beat, last_desc_beat, last_data_beat, in_data;
  logic [LEN_W-1:0]   new_len;

  assign nominal        = burst_words(burst_sel);
  assign chunk          = chunk_len(32'(remain), nominal);
  assign room           = (32'(fifo_count) + 32'(nominal)) <= 32'(DEPTH);
  assign in_data        = (state == S_BREQ) || (state == S_BWAIT);
  assign take           = (state == S_IDLE) && frame_start && list_valid;
  assign accept         = mem_req && mem_gnt;
  assign desc_beat      = (state == S_DWAIT) && mem_rvalid;
  assign last_desc_beat = desc_beat && (beats == BURST_W'(3));
  assign last_data_beat = (state == S_BWAIT) && mem_rvalid && (beats == BURST_W'(1));
  assign new_len        = mem_rdata[LEN_W-1:0];

  assign mem_req   = (state == S_DREQ) || ((state == S_BREQ) && room);
  assign mem_addr  = (state == S_DREQ) ? cur_desc : ptr;
  assign mem_len   = (state == S_DREQ) ? BURST_W'(4) : chunk;
  assign fifo_push = (state == S_BWAIT) && mem_rvalid;
  assign sof_flag  = sof_q;
  assign eof_flag  = (state == S_FIN) && sh_cmd[CMD_EOF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_desc <= '0;
      nxt      <= '0;
      ptr      <= '0;
      remain   <= '0;
      beats    <= '0;
      sh_buf   <= '0;
      sh_id    <= '0;
      sh_cmd   <= '0;
      sof_q    <= 1'b0;
    end else begin
      sof_q <= last_desc_beat && mem_rdata[CMD_SOF];
      case (state)
        S_IDLE: if (take) begin
          cur_desc <= head_pending ? head : nxt;
          state    <= S_DREQ;
        end
        S_DREQ: if (accept) begin
          beats <= '0;
          state <= S_DWAIT;
        end
        S_DWAIT: if (mem_rvalid) begin
          beats <= beats + 1'b1;
          case (beats[1:0])
            2'd0: nxt    <= mem_rdata;
            2'd1: sh_buf <= mem_rdata;
            2'd2: sh_id  <= mem_rdata;
            default: begin
              sh_cmd <= mem_rdata;
              ptr    <= sh_buf;
              remain <= new_len;
              state  <= (new_len == '0) ? S_FIN : S_BREQ;
            end
          endcase
        end
        S_BREQ: if (accept) begin
          ptr    <= ptr + {25'b0, chunk, 2'b00};
          remain <= remain - LEN_W'(chunk);
          beats  <= chunk;
          state  <= S_BWAIT;
        end
        S_BWAIT: if (mem_rvalid) begin
          beats <= beats - 1'b1;
          if (beats == BURST_W'(1)) state <= (remain == '0) ? S_FIN : S_BREQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) underflow <= 1'b0;
    else        underflow <= underflow | (in_data && pix_ready && fifo_empty);
  end

  // R2: a request keeps its address until granted
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R4: a data burst never reads past the length field
  assert_no_overread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_BREQ) && mem_req) |-> (32'(mem_len) <= 32'(remain)));

  // R5: bursts are never empty and never exceed 16 words
  assert_burst_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0 && mem_len <= BURST_W'(16)));

  // R6: an accepted data burst always fits in the FIFO
  assert_burst_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (state == S_BREQ)) |-> ((32'(fifo_count) + 32'(mem_len)) <= 32'(DEPTH)));

  // R7: data completion with nothing left always ends the frame
  assert_last_beat_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_data_beat && remain == '0) |=> (state == S_FIN));

  // R10: underflow is sticky
  assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

endmodule

// File: rtl/fb_desc_fetch.sv
module fb_desc_fetch
  import fbdf_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int FIFO_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [1:0]         burst_sel,
  input  logic               frame_start,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  output logic [BURST_W-1:0] mem_len,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               pix_valid,
  output logic [31:0]        pix_data,
  input  logic               pix_ready,
  output logic               sof_flag,
  output logic               eof_flag,
  output logic               pal_flag,
  output logic               underflow
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [31:0]      head, sh_buf, sh_id, sh_cmd;
  logic             head_pending, list_valid, take;
  logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_count;

  assign pix_valid = !fifo_empty;
  assign fifo_pop  = pix_ready && !fifo_empty;
  assign pal_flag  = sh_cmd[CMD_PAL];

  fbdf_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .take         (take),
    .sh_buf       (sh_buf),
    .sh_id        (sh_id),
    .sh_cmd       (sh_cmd),
    .head         (head),
    .head_pending (head_pending),
    .list_valid   (list_valid)
  );

  fbdf_engine #(.LEN_W(LEN_W), .DEPTH(FIFO_DEPTH)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .burst_sel    (burst_sel),
    .head         (head),
    .head_pending (head_pending),
    .list_valid   (list_valid),
    .take         (take),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_len      (mem_len),
    .mem_gnt      (mem_gnt),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .fifo_count   (fifo_count),
    .fifo_empty   (fifo_empty),
    .fifo_push    (fifo_push),
    .pix_ready    (pix_ready),
    .sh_buf       (sh_buf),
    .sh_id        (sh_id),
    .sh_cmd       (sh_cmd),
    .sof_flag     (sof_flag),
    .eof_flag     (eof_flag),
    .underflow    (underflow)
  );

  fbdf_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .wdata (mem_rdata),
    .pop   (fifo_pop),
    .rdata (pix_data),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  // R6: the FIFO reaches full only when the room rule allowed the final fill
  assert_full_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

endmodule

// File: tb/fb_desc_fetch_tb.sv
module fb_desc_fetch_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  burst_sel = 2'd0;
  logic        frame_start = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [4:0]  mem_len;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        pix_valid;
  logic [31:0] pix_data;
  logic        pix_ready = 1'b0;
  logic        sof_flag, eof_flag, pal_flag, underflow;

  fb_desc_fetch #(.LEN_W(12), .FIFO_DEPTH(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .burst_sel(burst_sel),
    .frame_start(frame_start), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .sof_flag(sof_flag), .eof_flag(eof_flag),
    .pal_flag(pal_flag), .underflow(underflow)
  );

  int tests = 0;
  int fails = 0;

  logic [31:0] mem [256];
  int          blog_addr [64];
  int          blog_len  [64];
  int          nburst = 0;
  logic [31:0] rx [128];
  int          rx_n = 0;
  int          sof_cnt = 0;
  int          eof_cnt = 0;
  bit          want_ready = 1'b0;
  int          beats_left = 0;
  int          pend_len = 0;
  logic [31:0] pend_addr = '0;
  logic [31:0] cur_a = '0;

  localparam logic [31:0] DESC_A = 32'h40;
  localparam logic [31:0] DESC_B = 32'h80;
  localparam logic [31:0] BUF_A  = 32'h100;
  localparam logic [31:0] BUF_B  = 32'h200;

  // memory, consumer and flag monitor, all on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      pix_ready = want_ready;
      if (pix_ready && pix_valid && rx_n < 128) begin
        rx[rx_n] = pix_data;
        rx_n++;
      end
      if (sof_flag) sof_cnt++;
      if (eof_flag) eof_cnt++;
      if (mem_gnt) begin
        mem_gnt    = 1'b0;
        beats_left = pend_len;
        cur_a      = pend_addr;
      end
      if (beats_left > 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[cur_a[9:2]];
        cur_a      = cur_a + 32'd4;
        beats_left--;
      end else begin
        mem_rvalid = 1'b0;
        if (mem_req) begin
          mem_gnt   = 1'b1;
          pend_addr = mem_addr;
          pend_len  = int'(mem_len);
          if (nburst < 64) begin
            blog_addr[nburst] = int'(mem_addr);
            blog_len[nburst]  = int'(mem_len);
          end
          nburst++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_desc(input logic [31:0] at, input logic [31:0] nx,
                          input logic [31:0] bf, input logic [31:0] id,
                          input logic [31:0] cmd);
    mem[at[9:2]]        = nx;
    mem[at[9:2] + 8'd1] = bf;
    mem[at[9:2] + 8'd2] = id;
    mem[at[9:2] + 8'd3] = cmd;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic wait_eof(input int e0);
    int n = 0;
    while (eof_cnt == e0 && n < 3000) begin cyc(1); n++; end
    chk("R7 eof pulse seen", 32'(eof_cnt - e0), 32'd1);
  endtask

  task automatic drain(input int exp_len);
    int n = 0;
    want_ready = 1'b1;
    while (rx_n < exp_len && n < 3000) begin cyc(1); n++; end
    cyc(3);
    want_ready = 1'b0;
    cyc(2);
    chk("R12 word count", 32'(rx_n), 32'(exp_len));
  endtask

  task automatic run_frame(input int exp_len, input bit early);
    int e0;
    nburst = 0; rx_n = 0; e0 = eof_cnt;
    if (early) want_ready = 1'b1;
    pulse_frame();
    wait_eof(e0);
    drain(exp_len);
  endtask

  // bursts after the descriptor read and the words delivered
  task automatic check_data(input logic [31:0] bf, input int len, input int sel);
    int b, rem, i;
    logic [31:0] a;
    b = (sel >= 2) ? 16 : (4 << sel);
    rem = len; a = bf; i = 1;
    while (rem > 0) begin
      int l;
      l = (rem < b) ? rem : b;
      chk("R5 burst length", 32'(blog_len[i]), 32'(l));
      chk("R4 burst address", 32'(blog_addr[i]), a);
      a = a + 32'(4 * l);
      rem -= l;
      i++;
    end
    chk("R4 burst count", 32'(nburst), 32'(i));
    for (int k = 0; k < len; k++)
      chk("R12 word value", rx[k], 32'hA000_0000 + (bf >> 2) + 32'(k));
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] cmd;
    int s0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
    set_desc(DESC_A, DESC_B, BUF_A, 32'h0000_00A1,
             (32'd1 << 31) | (32'd1 << 30) | (32'd1 << 28) | 32'd10);
    set_desc(DESC_B, DESC_B, BUF_B, 32'h0000_00B2, (32'd1 << 30) | 32'd5);

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 pix_valid", 32'(pix_valid), 32'd0);
    chk("R1 flags", {28'd0, sof_flag, eof_flag, pal_flag, underflow}, 32'd0);
    cfg_rd(8'h40, rd); chk("R1 head read", rd, 32'd0);
    cfg_rd(8'h44, rd); chk("R1 buf read", rd, 32'd0);
    cfg_rd(8'h48, rd); chk("R1 id read", rd, 32'd0);
    cfg_rd(8'h4C, rd); chk("R1 cmd read", rd, 32'd0);

    // R9 frame start before any head write is ignored
    nburst = 0;
    pulse_frame();
    cyc(20);
    chk("R9 no fetch without head", 32'(nburst), 32'd0);

    cfg_wr(8'h40, DESC_A);
    cfg_rd(8'h40, rd); chk("R3 head readback", rd, DESC_A);

    // first frame: descriptor A, 4-word bursts
    burst_sel = 2'd0;
    s0 = sof_cnt;
    run_frame(10, 1'b0);
    chk("R2 desc address", 32'(blog_addr[0]), DESC_A);
    chk("R2 desc length", 32'(blog_len[0]), 32'd4);
    check_data(BUF_A, 10, 0);
    cfg_rd(8'h44, rd); chk("R3 buf shadow", rd, BUF_A);
    cfg_rd(8'h48, rd); chk("R3 id shadow", rd, 32'h0000_00A1);
    cfg_rd(8'h4C, rd); chk("R3 cmd shadow", rd, mem[DESC_A[9:2] + 8'd3]);
    chk("R7 sof pulse", 32'(sof_cnt - s0), 32'd1);
    chk("R7 pal flag set", 32'(pal_flag), 32'd1);

    // R3 writes to shadow offsets are ignored
    cfg_wr(8'h44, 32'hDEAD_BEEF);
    cfg_wr(8'h48, 32'hDEAD_BEEF);
    cfg_wr(8'h4C, 32'hDEAD_BEEF);
    cfg_rd(8'h44, rd); chk("R3 buf write ignored", rd, BUF_A);
    cfg_rd(8'h48, rd); chk("R3 id write ignored", rd, 32'h0000_00A1);
    cfg_rd(8'h4C, rd); chk("R3 cmd write ignored", rd, mem[DESC_A[9:2] + 8'd3]);

    // second frame follows the next pointer to B
    run_frame(5, 1'b0);
    chk("R8 follow next pointer", 32'(blog_addr[0]), DESC_B);
    check_data(BUF_B, 5, 0);
    chk("R7 pal flag clear", 32'(pal_flag), 32'd0);

    // sweep: B points to itself, every select and length 0..20
    for (int sel = 0; sel < 4; sel++) begin
      for (int len = 0; len <= 20; len++) begin
        burst_sel = 2'(sel);
        cmd = (32'd1 << 30) | ((len % 2 == 1) ? (32'd1 << 31) : 32'd0) | 32'(len);
        mem[DESC_B[9:2] + 8'd3] = cmd;
        s0 = sof_cnt;
        run_frame(len, 1'b0);
        chk("R8 self pointer reload", 32'(blog_addr[0]), DESC_B);
        check_data(BUF_B, len, sel);
        chk("R7 sof by bit 31", 32'(sof_cnt - s0), 32'(len % 2));
        cfg_rd(8'h4C, rd); chk("R3 cmd shadow sweep", rd, cmd);
        if (len == 0) chk("R11 zero length no bursts", 32'(nburst), 32'd1);
      end
    end
    chk("R10 no underflow yet", 32'(underflow), 32'd0);

    // R6 stall on full FIFO, R9 head write mid-frame
    begin
      int e0;
      burst_sel = 2'd2;
      mem[DESC_B[9:2] + 8'd3] = (32'd1 << 30) | 32'd40;
      nburst = 0; rx_n = 0; e0 = eof_cnt;
      pulse_frame();
      cyc(100);
      chk("R6 stalled after two bursts", 32'(nburst), 32'd3);
      chk("R6 no request when full", 32'(mem_req), 32'd0);
      chk("R6 data waiting", 32'(pix_valid), 32'd1);
      cfg_wr(8'h40, DESC_A);
      cyc(5);
      chk("R9 frame unchanged by head write", 32'(nburst), 32'd3);
      want_ready = 1'b1;
      wait_eof(e0);
      drain(40);
      check_data(BUF_B, 40, 2);
      cfg_rd(8'h44, rd); chk("R9 shadow still B", rd, BUF_B);
    end

    run_frame(10, 1'b0);
    chk("R9 new head at next frame", 32'(blog_addr[0]), DESC_A);
    check_data(BUF_A, 10, 2);

    // R10 underflow: consumer demanding from frame start
    mem[DESC_B[9:2] + 8'd3] = (32'd1 << 30) | 32'd8;
    run_frame(8, 1'b1);
    chk("R10 underflow set", 32'(underflow), 32'd1);
    check_data(BUF_B, 8, 2);
    run_frame(8, 1'b0);
    chk("R10 underflow sticky", 32'(underflow), 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule